// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block sits inside an FPGA and gives an external board controller read and write access to a small bank of 32-bit configuration registers. The link is a slow synchronous serial one. The controller drives the serial clock, a direction line, a load strobe, an active-low reset and one serial data line. The block returns one serial data line. Every register word is also driven in parallel onto `cfg_regs_o`, so the rest of the chip can use it as a configuration setting.

Each access starts with a 12-bit address, sent MSB first. For a write, 32 data bits follow the address at once, and a rising edge on the load strobe commits the word. For a read, the load strobe follows the address. The addressed word is then captured into an output shifter and clocked back MSB first over the next 32 serial clocks. A faster system clock oversamples all the serial lines through two-flop synchronizers. All serial-side events are seen as edges in that clock domain.

A low level on the controller's reset line, or the on-chip synchronous reset, returns every register to its default value. Each load strobe also clears the bit counter and both shifters, so a broken transfer cannot shift the framing of the next one.

Top module: `cfg_serial_slave`

## Requirements
- R1: While `rst` is high, and after it is released, register n (bits [32n+31:32n] of `cfg_regs_o`) holds the default value 0xC0F00000 + n, and `sdata_out` is 0.
- R2: With `write_in` high, 12 address bits and then 32 data bits are sampled from `sdata_in` on rising `sclk_in` edges, MSB first. A rising edge on `load_in` after exactly 44 bits stores the data word in the addressed register.
- R3: With `write_in` low, 12 address bits followed by a rising `load_in` edge start a read. The addressed word appears on `sdata_out` MSB first. Bit 31 is valid after the load edge, and each falling `sclk_in` edge moves to the next bit, for 32 bits.
- R4: A write to a word address of 16 or more leaves all registers unchanged.
- R5: A read from a word address of 16 or more returns 32 zero bits.
- R6: A load edge that follows a bit count other than 44 for a write stores nothing. The next complete access still works normally.
- R7: `sdata_out` is 0 whenever no read data phase is in progress, including during write frames and after the 32nd read bit.
- R8: Holding `mrst_n_in` low restores every register to its default value, even after earlier writes.
- R9: Serial clock edges during a read data phase are not taken as address bits. A new access may begin right after the 32 read bits without an extra load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high system reset |
| sclk_in | input | 1 | Serial clock from the controller |
| mrst_n_in | input | 1 | Active-low default-reload request from the controller |
| load_in | input | 1 | Load strobe; its rising edge commits a write or starts read return |
| write_in | input | 1 | Access direction: 1 write, 0 read |
| sdata_in | input | 1 | Serial data from the controller |
| sdata_out | output | 1 | Serial read data to the controller |
| cfg_regs_o | output | NUM_REGS*32 (512) | All configuration registers, register n in bits [32n+31:32n] |

## Verification
A wrong bit count or shifter state shows up at the first load edge that follows. A write then lands in the wrong register, or lands nowhere, and `cfg_regs_o` shows this one system cycle after the synchronized load edge. A bad output shifter or read-active flag corrupts the returned word within the same read. It shows as a misplaced bit, a non-zero bit from an unused address, or a stray high level on `sdata_out` outside a read. A framing state that is not cleared by load, or a read phase that leaks into the input shifter, is caught by the next access, since the bench sends frames back to back.

// File: rtl/cfg_ser_pkg.sv
package cfg_ser_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int BIT_W   = $clog2(DATA_W);

    // serial-side events, already synchronized to clk
    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic load_rise;
        logic write;
        logic dbit;
        logic mrst;
    } ser_evt_t;

    // decoded access presented on a load edge
    typedef struct packed {
        logic              wr_stb;
        logic              rd_stb;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_req_t;

    function automatic logic [DATA_W-1:0] cfg_default(input logic [DATA_W-1:0] base,
                                                      input int idx);
        return base + DATA_W'(idx);
    endfunction

endpackage

// File: rtl/cfg_ser_front.sv
module cfg_ser_front
    import cfg_ser_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_in,
    input  logic     load_in,
    input  logic     write_in,
    input  logic     sdata_in,
    input  logic     mrst_n_in,
    output ser_evt_t evt_o
);

    localparam int LINES = 5;
    // line order inside a sync word: {mrst_n, data, write, load, sclk}
    localparam logic [LINES-1:0] IDLE_LINES = 5'b10000;

    logic [STAGES-1:0][LINES-1:0] sync_q;
    logic [LINES-1:0]             raw;
    logic [LINES-1:0]             last;
    logic                         sclk_prev_q;
    logic                         load_prev_q;

    assign raw  = {mrst_n_in, sdata_in, write_in, load_in, sclk_in};
    assign last = sync_q[STAGES-1];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[s] <= IDLE_LINES;
                end else if (s == 0) begin
                    sync_q[s] <= raw;
                end else begin
                    sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
            load_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= last[0];
            load_prev_q <= last[1];
        end
    end

    always_comb begin
        evt_o.sclk_rise = last[0] & ~sclk_prev_q;
        evt_o.sclk_fall = ~last[0] & sclk_prev_q;
        evt_o.load_rise = last[1] & ~load_prev_q;
        evt_o.write     = last[2];
        evt_o.dbit      = last[3];
        evt_o.mrst      = ~last[4];
    end

endmodule

// File: rtl/cfg_ser_rx.sv
module cfg_ser_rx
    import cfg_ser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ser_evt_t         evt_i,
    input  logic             hold_i,
    output cfg_req_t         req_o,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic               full;
    logic               addr_only;

    assign full      = (cnt_q == CNT_W'(FRAME_W));
    assign addr_only = (cnt_q == CNT_W'(ADDR_W));

    always_ff @(posedge clk) begin
        if (rst || evt_i.mrst || evt_i.load_rise) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (evt_i.sclk_rise && !hold_i && !full) begin
            sh_q  <= {sh_q[FRAME_W-2:0], evt_i.dbit};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        req_o.wr_stb = evt_i.load_rise && !evt_i.mrst && evt_i.write && full;
        req_o.rd_stb = evt_i.load_rise && !evt_i.mrst && !evt_i.write && addr_only;
        req_o.addr   = evt_i.write ? sh_q[FRAME_W-1:DATA_W] : sh_q[ADDR_W-1:0];
        req_o.data   = sh_q[DATA_W-1:0];
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/cfg_ser_regfile.sv
module cfg_ser_regfile
    import cfg_ser_pkg::*;
#(
    parameter int                NUM_REGS = 16,
    parameter logic [DATA_W-1:0] DEF_BASE = 32'hC0F0_0000
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mrst_i,
    input  cfg_req_t                     req_i,
    output logic [DATA_W-1:0]            rd_data_o,
    output logic [NUM_REGS*DATA_W-1:0]   regs_o
);

    logic [DATA_W-1:0] word_q [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst || mrst_i) begin
                    word_q[g] <= cfg_default(DEF_BASE, g);
                end else if (req_i.wr_stb && req_i.addr == ADDR_W'(g)) begin
                    word_q[g] <= req_i.data;
                end
            end
            assign regs_o[g*DATA_W +: DATA_W] = word_q[g];
        end
    endgenerate

    // unmatched addresses read as zero
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (req_i.addr == ADDR_W'(i)) begin
                rd_data_o = word_q[i];
            end
        end
    end

endmodule

// File: rtl/cfg_ser_tx.sv
module cfg_ser_tx
    import cfg_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ser_evt_t          evt_i,
    input  cfg_req_t          req_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              active_o,
    output logic              sdo_o
);

    logic [DATA_W-1:0] sh_q;
    logic [BIT_W-1:0]  bit_q;
    logic              active_q;

    always_ff @(posedge clk) begin
        if (rst || evt_i.mrst) begin
            sh_q     <= '0;
            bit_q    <= '0;
            active_q <= 1'b0;
        end else if (evt_i.load_rise) begin
            bit_q    <= '0;
            active_q <= req_i.rd_stb;
            sh_q     <= req_i.rd_stb ? rd_data_i : '0;
        end else if (evt_i.sclk_fall && active_q) begin
            if (bit_q == BIT_W'(DATA_W-1)) begin
                active_q <= 1'b0;
                sh_q     <= '0;
            end else begin
                sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                bit_q <= bit_q + 1'b1;
            end
        end
    end

    assign active_o = active_q;
    assign sdo_o    = active_q & sh_q[DATA_W-1];

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfg_ser_pkg::*;
#(
    parameter int                NUM_REGS = 16,
    parameter logic [DATA_W-1:0] DEF_BASE = 32'hC0F0_0000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk_in,
    input  logic                       mrst_n_in,
    input  logic                       load_in,
    input  logic                       write_in,
    input  logic                       sdata_in,
    output logic                       sdata_out,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs_o
);

    ser_evt_t          evt;
    cfg_req_t          req;
    logic [CNT_W-1:0]  rx_cnt;
    logic [DATA_W-1:0] rd_data;
    logic              tx_active;

    cfg_ser_front #(.STAGES(2)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (sclk_in),
        .load_in   (load_in),
        .write_in  (write_in),
        .sdata_in  (sdata_in),
        .mrst_n_in (mrst_n_in),
        .evt_o     (evt)
    );

    cfg_ser_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .hold_i (tx_active),
        .req_o  (req),
        .cnt_o  (rx_cnt)
    );

    cfg_ser_regfile #(.NUM_REGS(NUM_REGS), .DEF_BASE(DEF_BASE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .mrst_i    (evt.mrst),
        .req_i     (req),
        .rd_data_o (rd_data),
        .regs_o    (cfg_regs_o)
    );

    cfg_ser_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .req_i     (req),
        .rd_data_i (rd_data),
        .active_o  (tx_active),
        .sdo_o     (sdata_out)
    );

endmodule

// File: rtl/cfg_ser_chk.sv
module cfg_ser_chk
    import cfg_ser_pkg::*;
#(
    parameter int                NUM_REGS = 16,
    parameter logic [DATA_W-1:0] DEF_BASE = 32'hC0F0_0000
) (
    input logic                       clk,
    input logic                       rst,
    input ser_evt_t                   evt,
    input cfg_req_t                   req,
    input logic [CNT_W-1:0]           rx_cnt,
    input logic                       tx_active,
    input logic                       sdata_out,
    input logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

    logic [NUM_REGS*DATA_W-1:0] all_def;
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            all_def[i*DATA_W +: DATA_W] = DEF_BASE + DATA_W'(i);
        end
    end

    // R8
    mrst_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        evt.mrst |=> cfg_regs == all_def);

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (req.wr_stb && req.addr < ADDR_W'(NUM_REGS))
        |=> cfg_regs[int'($past(req.addr)) * DATA_W +: DATA_W] == $past(req.data));

    // R4
    regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!req.wr_stb && !evt.mrst) |=> $stable(cfg_regs));

    // R3
    read_starts_chk: assert property (@(posedge clk) disable iff (rst)
        req.rd_stb |=> tx_active);

    // R5
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req.rd_stb && req.addr >= ADDR_W'(NUM_REGS)) |=> !sdata_out);

    // R7
    quiet_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.load_rise && !req.rd_stb) |=> !sdata_out);

    // R6
    load_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
        evt.load_rise |=> rx_cnt == '0);

    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rx_cnt <= CNT_W'(FRAME_W));

    // R9
    read_phase_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !evt.load_rise && !evt.mrst) |=> $stable(rx_cnt));

endmodule

bind cfg_serial_slave cfg_ser_chk #(.NUM_REGS(NUM_REGS), .DEF_BASE(DEF_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .req       (req),
    .rx_cnt    (rx_cnt),
    .tx_active (tx_active),
    .sdata_out (sdata_out),
    .cfg_regs  (cfg_regs_o)
);

// File: tb/test_cfg_serial_slave.sv
`timescale 1ns/1ps
module test_cfg_serial_slave;

    localparam int NREG = 16;
    localparam int HALF = 10;
    localparam int NVEC = 8;
    // {write, addr[11:0], data[31:0]}
    localparam logic [44:0] VECS [NVEC] = '{
        {1'b1, 12'h003, 32'hDEAD_BEEF},
        {1'b0, 12'h003, 32'h0},
        {1'b1, 12'h00F, 32'h1234_5678},
        {1'b0, 12'h00F, 32'h0},
        {1'b0, 12'h000, 32'h0},
        {1'b1, 12'h000, 32'hA5A5_0F0F},
        {1'b0, 12'h000, 32'h0},
        {1'b0, 12'h007, 32'h0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, sclk_in, mrst_n_in, load_in, write_in, sdata_in, sdata_out;
    logic [NREG*32-1:0] cfg_regs_o;

    cfg_serial_slave i_cfg_serial_slave (
        .clk(clk), .rst(rst), .sclk_in(sclk_in), .mrst_n_in(mrst_n_in),
        .load_in(load_in), .write_in(write_in), .sdata_in(sdata_in),
        .sdata_out(sdata_out), .cfg_regs_o(cfg_regs_o)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [NREG];
    logic [31:0] got;

    function automatic logic [31:0] dflt(input int n);
        return 32'hC0F0_0000 + 32'(n);
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < NREG; i++) model[i] = dflt(i);
    endtask

    task automatic check_regs(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < NREG; i++) begin
            if (cfg_regs_o[i*32 +: 32] !== model[i] && bad < 0) bad = i;
        end
        if (bad < 0) check(1'b1, req, 32'h0, 32'h0);
        else check(1'b0, req, cfg_regs_o[bad*32 +: 32], model[bad]);
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b;
        wait_n(HALF);
        sclk_in = 1'b1;
        wait_n(HALF);
        sclk_in = 1'b0;
    endtask

    task automatic pulse_load();
        wait_n(HALF);
        load_in = 1'b1;
        wait_n(HALF);
        load_in = 1'b0;
        wait_n(HALF);
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d, input int nbits);
        logic [43:0] fr;
        fr = {a, d};
        write_in = 1'b1;
        for (int i = 43; i > 43 - nbits; i--) send_bit(fr[i]);
        pulse_load();
        if (nbits == 44 && a < NREG) model[a] = d;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] r);
        write_in = 1'b0;
        for (int i = 11; i >= 0; i--) send_bit(a[i]);
        pulse_load();
        for (int i = 31; i >= 0; i--) begin
            r[i] = sdata_out;
            sclk_in = 1'b1;
            wait_n(HALF);
            sclk_in = 1'b0;
            wait_n(HALF);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; mrst_n_in = 1'b1; sclk_in = 1'b0; load_in = 1'b0;
        write_in = 1'b0; sdata_in = 1'b0;
        reset_model();
        wait_n(5);
        check_regs("R1 defaults during reset");
        rst = 1'b0;
        wait_n(5);
        check_regs("R1 defaults after reset");
        check(sdata_out == 1'b0, "R1 output idle", 32'(sdata_out), 32'h0);

        // vector table, frames back to back (R9 covers read then write)
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v][44]) begin
                do_write(VECS[v][43:32], VECS[v][31:0], 44);
                check_regs("R2 write frame");
                check(sdata_out == 1'b0, "R7 idle after write", 32'(sdata_out), 32'h0);
            end else begin
                do_read(VECS[v][43:32], got);
                check(got == model[VECS[v][43:32]], "R3 R9 read frame", got,
                      model[VECS[v][43:32]]);
                check(sdata_out == 1'b0, "R7 idle after read", 32'(sdata_out), 32'h0);
            end
        end

        // R4 write above the bank
        do_write(12'h020, 32'hFFFF_FFFF, 44);
        check_regs("R4 unused write ignored");
        do_write(12'h010, 32'h5555_AAAA, 44);
        check_regs("R4 address 16 ignored");

        // R5 reads above the bank
        do_read(12'h010, got);
        check(got == 32'h0, "R5 read address 16", got, 32'h0);
        do_read(12'hFFF, got);
        check(got == 32'h0, "R5 read address FFF", got, 32'h0);

        // R6 short write then a full one
        do_write(12'h005, 32'h0BAD_F00D, 20);
        check_regs("R6 partial write dropped");
        do_write(12'h005, 32'h600D_CAFE, 44);
        check_regs("R6 next write intact");
        do_read(12'h005, got);
        check(got == 32'h600D_CAFE, "R6 readback after partial", got, 32'h600D_CAFE);

        // R7 output during a write frame
        write_in = 1'b1;
        for (int i = 0; i < 8; i++) send_bit(i[0]);
        check(sdata_out == 1'b0, "R7 idle mid write", 32'(sdata_out), 32'h0);
        pulse_load();
        check_regs("R6 aborted frame dropped");

        // R8 controller reset reload
        mrst_n_in = 1'b0;
        wait_n(HALF);
        mrst_n_in = 1'b1;
        wait_n(HALF);
        reset_model();
        check_regs("R8 defaults restored");
        do_read(12'h003, got);
        check(got == dflt(3), "R8 read after reload", got, dflt(3));

        // R1 system reset after writes
        do_write(12'h002, 32'h1357_9BDF, 44);
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(3);
        reset_model();
        check_regs("R1 defaults after second reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule